// File: doc/BRIEF.md
# Synchronous buck gate-drive sequencer

This block is the digital heart of a half-bridge driver for one synchronous buck phase. A PWM command comes in already resolved into three levels (high, low, or a middle level for a released controller output). The block turns that command into two gate enables, one for the high-side switch and one for the low-side switch. Before either gate turns on, the other gate must be off: a programmable count of clock cycles must pass, and a comparator flag must report that the opposite gate voltage has dropped below its safe level.

A second three-level input picks the conduction style. At low level the phase may run in diode emulation: a zero-crossing flag ends the low-side interval early, and the switch stays off until the next high command. At high level the low-side switch conducts for the whole low interval. At the middle level, meaning the pin is left floating, the block goes into a low-power shutdown once the PWM command has also stayed in its middle level for the hold-off time. An undervoltage flag overrides everything else and forces both gates off.

Top module: `buck_gate_seq`

## Requirements
- R1: With PWM high (`pwmLvl`=01) and the turn-on conditions met, `hsGate`=1 and `lsGate`=0.
- R2: With PWM low (`pwmLvl`=00) and forced conduction (`modeLvl`=01), `lsGate`=1 and `hsGate`=0, and this holds through the whole low interval.
- R3: The two gates are never 1 together. Once a gate has dropped, the opposite gate rises after exactly DEAD_CYC+1 cycles with both low, provided its comparator flag is held at 1.
- R4: `hsGate` cannot rise while `lsBelow`=0, and `lsGate` cannot rise while `hsBelow`=0. The waiting gate rises on the first clock edge after the flag returns, if the delay has already passed.
- R5: When `pwmLvl` (1x = middle) stays in the middle level for HOLDOFF_CYC consecutive clock edges, both gates drop on that last edge. Before then, the previous gate state is held. Any high or low sample restarts the count.
- R6: With `modeLvl`=00, `zeroCross`=1 while the low-side switch is on turns `lsGate` off on the next edge. The gate stays off for the rest of the low interval, whatever `zeroCross` does.
- R7: With `modeLvl`=01, `zeroCross` has no effect, and `lsGate` stays 1.
- R8: A mode change takes effect on the next clock edge without waiting for a PWM edge. From a diode-emulation cutoff, a switch to `modeLvl`=01 starts the low-side turn-on at once, and the gate rises DEAD_CYC+1 cycles later.
- R9: A middle-level `modeLvl` (1x), together with an expired PWM hold-off, sets `lowPower`=1 with both gates off. Leaving the middle mode level clears `lowPower` on the next edge.
- R10: `uvlo`=1 forces both gates to 0 in the same cycle, with no clock edge needed. Once `uvlo` returns to 0, a gate rises only after the full dead-time sequence.
- R11: Recovery from the hold-off state or from shutdown starts only on a high or low PWM level. That first edge also clears `lowPower`.
- R12: During reset and right after it, both gates and `lowPower` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwmLvl | input | 2 | Decoded PWM level: 00 low, 01 high, 1x middle |
| modeLvl | input | 2 | Decoded mode level: 00 diode emulation, 01 forced conduction, 1x floating |
| zeroCross | input | 1 | Inductor current has reached zero |
| hsBelow | input | 1 | High-side gate voltage is below the safe level |
| lsBelow | input | 1 | Low-side gate voltage is below the safe level |
| uvlo | input | 1 | Supply undervoltage; gates clamped while 1 |
| hsGate | output | 1 | High-side gate enable |
| lsGate | output | 1 | Low-side gate enable |
| lowPower | output | 1 | Shutdown / low-power state indicator |

## Verification
Most results show up one clock edge after the input that causes them. This covers the zero-crossing cutoff, mode changes, the entry into and exit from shutdown, and the start of a dead interval. A gate turn-on is the exception: it appears DEAD_CYC+2 edges after the command, because the first edge only enters the dead interval. The hold-off cutoff lands on the HOLDOFF_CYC-th middle-level edge. The undervoltage clamp needs no edge at all. Each vector in the bench states how many edges to wait before its outputs are read at the falling edge. Where a turn-on is expected, the wait is split so that one check falls on the last cycle before the rise and the next falls on the first cycle after it. The undervoltage clamp is read one time step after the flag is driven, before any clock edge.

// File: rtl/buck_gate_pkg.sv
package buck_gate_pkg;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_SHDN,
    ST_DEADH,
    ST_HS,
    ST_DEADL,
    ST_LS,
    ST_DCM
  } seqState_t;

  typedef struct packed {
    logic deadClr;
    logic deadRun;
  } seqStrobe_t;

  localparam logic [1:0] LVL_LOW  = 2'b00;
  localparam logic [1:0] LVL_HIGH = 2'b01;

endpackage

// File: rtl/buck_gate_dp.sv
module buck_gate_dp
  import buck_gate_pkg::*;
#(
  parameter int HOLDOFF_CYC = 8,
  parameter int DEAD_CYC    = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwmMid,
  input  seqStrobe_t strobe,
  output logic       holdDone,
  output logic       deadDone
);

  localparam int HOLD_W = $clog2(HOLDOFF_CYC + 2);
  localparam logic [HOLD_W-1:0] HOLD_MAX  = HOLD_W'(HOLDOFF_CYC);
  localparam logic [HOLD_W-1:0] HOLD_LAST = HOLD_W'(HOLDOFF_CYC - 1);

  logic [HOLD_W-1:0] holdCnt;

  // Counts consecutive middle-level PWM samples, saturating.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      holdCnt <= '0;
    end else if (!pwmMid) begin
      holdCnt <= '0;
    end else if (holdCnt < HOLD_MAX) begin
      holdCnt <= holdCnt + 1'b1;
    end
  end

  assign holdDone = pwmMid && (holdCnt >= HOLD_LAST);

  generate
    if (DEAD_CYC == 0) begin : g_noDelay
      assign deadDone = 1'b1;
    end else begin : g_delay
      localparam int DEAD_W = $clog2(DEAD_CYC + 2);
      localparam logic [DEAD_W-1:0] DEAD_MAX = DEAD_W'(DEAD_CYC);
      logic [DEAD_W-1:0] deadCnt;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          deadCnt <= '0;
        end else if (strobe.deadClr) begin
          deadCnt <= '0;
        end else if (strobe.deadRun && deadCnt < DEAD_MAX) begin
          deadCnt <= deadCnt + 1'b1;
        end
      end

      assign deadDone = (deadCnt >= DEAD_MAX);
    end
  endgenerate

endmodule

// File: rtl/buck_gate_ctrl.sv
module buck_gate_ctrl
  import buck_gate_pkg::*;
#(
  parameter int DEAD_CYC = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] pwmLvl,
  input  logic [1:0] modeLvl,
  input  logic       zeroCross,
  input  logic       hsBelow,
  input  logic       lsBelow,
  input  logic       uvlo,
  input  logic       holdDone,
  input  logic       deadDone,
  output seqStrobe_t strobe,
  output logic       hsGate,
  output logic       lsGate,
  output logic       lowPower
);

  seqState_t state, nextState;

  logic pwmHi, pwmLo, modeFloat, modeCcm;
  assign pwmHi     = (pwmLvl == LVL_HIGH);
  assign pwmLo     = (pwmLvl == LVL_LOW);
  assign modeFloat = modeLvl[1];
  assign modeCcm   = (modeLvl == LVL_HIGH);

  always_comb begin
    nextState = state;
    if (uvlo) begin
      nextState = ST_OFF;
    end else if (holdDone) begin
      nextState = modeFloat ? ST_SHDN : ST_OFF;
    end else begin
      case (state)
        ST_OFF, ST_SHDN: begin
          if (pwmHi)      nextState = ST_DEADH;
          else if (pwmLo) nextState = ST_DEADL;
        end
        ST_DEADH: begin
          if (pwmLo)                              nextState = ST_DEADL;
          else if (pwmHi && deadDone && lsBelow)  nextState = ST_HS;
        end
        ST_HS: begin
          if (pwmLo) nextState = ST_DEADL;
        end
        ST_DEADL: begin
          if (pwmHi)                              nextState = ST_DEADH;
          else if (pwmLo && deadDone && hsBelow)  nextState = ST_LS;
        end
        ST_LS: begin
          if (pwmHi)                                  nextState = ST_DEADH;
          else if (pwmLo && !modeCcm && zeroCross)    nextState = ST_DCM;
        end
        ST_DCM: begin
          if (pwmHi)                nextState = ST_DEADH;
          else if (pwmLo && modeCcm) nextState = ST_DEADL;
        end
        default: nextState = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_OFF;
    else        state <= nextState;
  end

  assign strobe.deadClr = ((nextState == ST_DEADH) || (nextState == ST_DEADL)) &&
                          (nextState != state);
  assign strobe.deadRun = (state == ST_DEADH) || (state == ST_DEADL);

  // Supply loss clamps the gates without waiting for a clock edge.
  assign hsGate   = (state == ST_HS) && !uvlo;
  assign lsGate   = (state == ST_LS) && !uvlo;
  assign lowPower = (state == ST_SHDN);

  // Run length of both-gates-low, used by the dead-time properties.
  localparam int GAP_W = $clog2(DEAD_CYC + 3);
  localparam logic [GAP_W-1:0] GAP_MAX = GAP_W'(DEAD_CYC + 1);
  logic [GAP_W-1:0] gapCnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                gapCnt <= '0;
    else if (hsGate || lsGate) gapCnt <= '0;
    else if (gapCnt < GAP_MAX) gapCnt <= gapCnt + 1'b1;
  end

  a_r3_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(hsGate && lsGate));

  a_r3_hs_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hsGate) |-> (gapCnt == GAP_MAX));

  a_r3_ls_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lsGate) |-> (gapCnt == GAP_MAX));

  a_r4_hs_waits: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hsGate) |-> $past(lsBelow));

  a_r4_ls_waits: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lsGate) |-> $past(hsBelow));

  a_r6_zc_cut: assert property (@(posedge clk) disable iff (!rst_n)
    (lsGate && pwmLo && !modeCcm && zeroCross) |=> !lsGate);

  a_r9_lp_gates_off: assert property (@(posedge clk) disable iff (!rst_n)
    lowPower |-> (!hsGate && !lsGate));

  a_r10_uvlo_after: assert property (@(posedge clk) disable iff (!rst_n)
    uvlo |=> (!hsGate && !lsGate));

endmodule

// File: rtl/buck_gate_seq.sv
module buck_gate_seq
  import buck_gate_pkg::*;
#(
  parameter int HOLDOFF_CYC = 8,
  parameter int DEAD_CYC    = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] pwmLvl,
  input  logic [1:0] modeLvl,
  input  logic       zeroCross,
  input  logic       hsBelow,
  input  logic       lsBelow,
  input  logic       uvlo,
  output logic       hsGate,
  output logic       lsGate,
  output logic       lowPower
);

  seqStrobe_t strobe;
  logic holdDone, deadDone, pwmMid;

  assign pwmMid = pwmLvl[1];

  buck_gate_dp #(
    .HOLDOFF_CYC(HOLDOFF_CYC),
    .DEAD_CYC   (DEAD_CYC)
  ) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .pwmMid  (pwmMid),
    .strobe  (strobe),
    .holdDone(holdDone),
    .deadDone(deadDone)
  );

  buck_gate_ctrl #(
    .DEAD_CYC(DEAD_CYC)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwmLvl   (pwmLvl),
    .modeLvl  (modeLvl),
    .zeroCross(zeroCross),
    .hsBelow  (hsBelow),
    .lsBelow  (lsBelow),
    .uvlo     (uvlo),
    .holdDone (holdDone),
    .deadDone (deadDone),
    .strobe   (strobe),
    .hsGate   (hsGate),
    .lsGate   (lsGate),
    .lowPower (lowPower)
  );

endmodule

// File: tb/buck_gate_seq_test.sv
module buck_gate_seq_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] pwmLvl = 2'b10;
  logic [1:0] modeLvl = 2'b01;
  logic zeroCross = 1'b0;
  logic hsBelow = 1'b1;
  logic lsBelow = 1'b1;
  logic uvlo = 1'b0;
  logic hsGate, lsGate, lowPower;

  int checks = 0;
  int fails = 0;
  int overlapCnt = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  buck_gate_seq uut (
    .clk(clk), .rst_n(rst_n), .pwmLvl(pwmLvl), .modeLvl(modeLvl),
    .zeroCross(zeroCross), .hsBelow(hsBelow), .lsBelow(lsBelow), .uvlo(uvlo),
    .hsGate(hsGate), .lsGate(lsGate), .lowPower(lowPower)
  );

  // Defaults: DEAD_CYC=3, HOLDOFF_CYC=8.
  // pwm: 00 low, 01 high, 10 middle.  mode: 00 emulation, 01 forced, 10 float.
  typedef struct packed {
    logic [1:0] pwm;
    logic [1:0] mode;
    logic       zc;
    logic [7:0] cyc;
    logic       hs;
    logic       ls;
    logic       lp;
    logic [3:0] req;
  } vec_t;

  localparam int NVEC = 21;
  localparam vec_t VECS [0:NVEC-1] = '{
    '{2'b01, 2'b01, 1'b0, 8'd4, 1'b0, 1'b0, 1'b0, 4'd3},   // R3 last dead cycle
    '{2'b01, 2'b01, 1'b0, 8'd1, 1'b1, 1'b0, 1'b0, 4'd1},   // R1 high side on
    '{2'b00, 2'b01, 1'b0, 8'd1, 1'b0, 1'b0, 1'b0, 4'd3},   // R3 hs drops at once
    '{2'b00, 2'b01, 1'b0, 8'd3, 1'b0, 1'b0, 1'b0, 4'd3},   // R3 still dead
    '{2'b00, 2'b01, 1'b0, 8'd1, 1'b0, 1'b1, 1'b0, 4'd2},   // R2 low side on
    '{2'b00, 2'b01, 1'b1, 8'd2, 1'b0, 1'b1, 1'b0, 4'd7},   // R7 zc ignored
    '{2'b00, 2'b00, 1'b1, 8'd1, 1'b0, 1'b0, 1'b0, 4'd6},   // R6 zc cutoff
    '{2'b00, 2'b00, 1'b0, 8'd5, 1'b0, 1'b0, 1'b0, 4'd6},   // R6 stays off
    '{2'b00, 2'b01, 1'b0, 8'd4, 1'b0, 1'b0, 1'b0, 4'd8},   // R8 dead after mode flip
    '{2'b00, 2'b01, 1'b0, 8'd1, 1'b0, 1'b1, 1'b0, 4'd8},   // R8 low side back on
    '{2'b10, 2'b01, 1'b0, 8'd7, 1'b0, 1'b1, 1'b0, 4'd5},   // R5 hold before expiry
    '{2'b10, 2'b01, 1'b0, 8'd1, 1'b0, 1'b0, 1'b0, 4'd5},   // R5 expiry
    '{2'b10, 2'b10, 1'b0, 8'd1, 1'b0, 1'b0, 1'b1, 4'd9},   // R9 shutdown
    '{2'b10, 2'b00, 1'b0, 8'd1, 1'b0, 1'b0, 1'b0, 4'd9},   // R9 leave float
    '{2'b10, 2'b10, 1'b0, 8'd1, 1'b0, 1'b0, 1'b1, 4'd9},   // R9 shutdown again
    '{2'b01, 2'b10, 1'b0, 8'd1, 1'b0, 1'b0, 1'b0, 4'd11},  // R11 wake on high
    '{2'b01, 2'b10, 1'b0, 8'd4, 1'b1, 1'b0, 1'b0, 4'd11},  // R11 hs after dead
    '{2'b10, 2'b01, 1'b0, 8'd5, 1'b1, 1'b0, 1'b0, 4'd5},   // R5 short middle run
    '{2'b01, 2'b01, 1'b0, 8'd1, 1'b1, 1'b0, 1'b0, 4'd5},   // R5 count restart
    '{2'b10, 2'b01, 1'b0, 8'd7, 1'b1, 1'b0, 1'b0, 4'd5},   // R5 fresh count
    '{2'b10, 2'b01, 1'b0, 8'd1, 1'b0, 1'b0, 1'b0, 4'd5}    // R5 expiry
  };

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s {hs,ls,lp} actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(negedge clk) if (hsGate && lsGate) overlapCnt++;

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      finishRun();
    end
  end

  initial begin
    // R12: reset state
    tick(3);
    check("R12 in reset", {hsGate, lsGate, lowPower}, 3'b000);
    rst_n = 1'b1;
    tick(1);
    check("R12 after reset", {hsGate, lsGate, lowPower}, 3'b000);

    for (int i = 0; i < NVEC; i++) begin
      pwmLvl    = VECS[i].pwm;
      modeLvl   = VECS[i].mode;
      zeroCross = VECS[i].zc;
      tick(int'(VECS[i].cyc));
      check($sformatf("R%0d vector %0d", VECS[i].req, i),
            {hsGate, lsGate, lowPower}, {VECS[i].hs, VECS[i].ls, VECS[i].lp});
    end

    // R4: turn-on waits for the opposite comparator flag
    pwmLvl = 2'b00; modeLvl = 2'b01; zeroCross = 1'b0;
    tick(5);
    check("R4 low side up", {hsGate, lsGate, lowPower}, 3'b010);
    lsBelow = 1'b0;
    pwmLvl = 2'b01;
    tick(10);
    check("R4 hs held by lsBelow", {hsGate, lsGate, lowPower}, 3'b000);
    lsBelow = 1'b1;
    tick(1);
    check("R4 hs rises on flag", {hsGate, lsGate, lowPower}, 3'b100);

    // R10: undervoltage clamp and recovery
    uvlo = 1'b1;
    #1;
    check("R10 immediate clamp", {hsGate, lsGate, lowPower}, 3'b000);
    tick(2);
    check("R10 held", {hsGate, lsGate, lowPower}, 3'b000);
    uvlo = 1'b0;
    tick(4);
    check("R10 dead after release", {hsGate, lsGate, lowPower}, 3'b000);
    tick(1);
    check("R10 hs back", {hsGate, lsGate, lowPower}, 3'b100);

    // R3: no cycle with both gates on
    checks++;
    if (overlapCnt != 0) begin
      fails++;
      $display("FAIL R3 overlap cycles actual=%0d expected=0", overlapCnt);
    end

    done = 1'b1;
    finishRun();
  end

endmodule